// File: doc/BRIEF.md
# Boot Image CRC Validation Sequencer

This block runs once after reset and decides whether the processor may jump into its application image or must remain in update (loader) mode. It streams the application region of program memory through a synchronous read port, one byte per cycle, folds every byte into a CRC-16, then fetches the two stored checksum bytes that sit directly after the image. If the image checksum holds, it also fetches a second copy of the checksum from a small nonvolatile memory and compares it.

A full double match raises a sticky start-application output. Any mismatch puts the block in loader mode, with both indicator outputs lit. A separate image-download engine is expected to run in that mode. When the image itself was sound and only the nonvolatile copy disagreed, the block arms a recovery timer. If no loader activity is seen before the timer expires, the block writes the freshly computed checksum into the nonvolatile copy and then starts the application. Any activity in loader mode disarms the recovery for good.

The only data that leaves the block is the nonvolatile write stream. It is a valid/ready byte interface. `nv_wr_valid`, `nv_wr_addr` and `nv_wr_data` stay asserted and unchanged until the cycle in which `nv_wr_ready` is high. A byte is taken in that cycle. The writer can stall for any number of cycles. Both memory read ports are plain request ports with a fixed one-cycle read latency and no back-pressure.

Top module: `boot_crc_seq`

## Requirements
- R1: Starting in the first cycle after reset release (cycle 0), `pm_rd_en` is high for exactly N = IMG_LAST-IMG_FIRST+3 consecutive cycles. In cycle k it presents address IMG_FIRST+k, so the image is read first and then the two stored checksum bytes.
- R2: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. Bytes are processed most significant bit first, with no final inversion. The nine ASCII bytes "123456789" yield 0x29B1.
- R3: The stored checksum is big-endian: the high byte is at IMG_LAST+1 and the low byte at IMG_LAST+2. On a mismatch, `loader_mode` rises in cycle N+2 and `img_valid` stays low.
- R4: On an image match, `img_valid` rises in cycle N+2 and stays high. `nv_rd_en` is high in cycles N+2 and N+3, with addresses NV_CRC_ADDR and NV_CRC_ADDR+1. The high byte of the copy is at the lower address.
- R5: If the nonvolatile copy also matches, `start_app` rises in cycle N+6 and `loader_mode` never rises.
- R6: If the image matches but the copy differs, `loader_mode` rises in cycle N+6.
- R7: `ind_a` and `ind_b` are both high exactly while `loader_mode` is high, and both are low otherwise.
- R8: When loader mode was entered with `img_valid` high and no activity has been seen, the recovery write starts after TICK_DIV*TIMEOUT_TICKS cycles of loader mode. The write sends the checksum high byte to NV_CRC_ADDR and then the low byte to NV_CRC_ADDR+1, each held until accepted. `start_app` rises the cycle after the second byte is accepted, and loader mode ends at the same time.
- R9: A high `ldr_activity` in any loader-mode cycle cancels the recovery permanently. No write is issued, the nonvolatile contents stay unchanged, and `loader_mode` stays high.
- R10: When loader mode was entered with `img_valid` low, no write is ever issued and `start_app` never rises.
- R11: All decision outputs are low during reset. Once `start_app` is high it stays high, and it is never high unless `img_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_rd_en | output | 1 | Program memory read request |
| pm_addr | output | PM_AW | Program memory read address |
| pm_rdata | input | 8 | Program memory data, one cycle after request |
| nv_rd_en | output | 1 | Nonvolatile memory read request |
| nv_rd_addr | output | NV_AW | Nonvolatile read address |
| nv_rdata | input | 8 | Nonvolatile data, one cycle after request |
| nv_wr_valid | output | 1 | Write byte offered |
| nv_wr_addr | output | NV_AW | Write address |
| nv_wr_data | output | 8 | Write byte |
| nv_wr_ready | input | 1 | Byte accepted in this cycle |
| ldr_activity | input | 1 | Loader traffic seen; cancels recovery |
| loader_mode | output | 1 | Block holds in loader mode |
| ind_a | output | 1 | Loader indicator A |
| ind_b | output | 1 | Loader indicator B |
| img_valid | output | 1 | Image checksum matched |
| start_app | output | 1 | Application may start (sticky) |

## Verification
Every output is due at a fixed cycle, counted from the first edge after reset release.
- The read address matches in the same cycle as its request.
- `img_valid` and the bad-image loader entry follow at N+2.
- The nonvolatile reads come at N+2 and N+3.
- The start-or-loader decision comes at N+6.
- The recovery write starts TICK_DIV*TIMEOUT_TICKS cycles after loader entry.
- `start_app` follows two cycles after each write byte has waited one cycle for its ready.

The bench turns these numbers into an expected timeline for each scenario, with the values taken from its own checksum model. It samples every output just after each falling edge and compares it with that timeline.

// File: rtl/boot_crc_pkg.sv
package boot_crc_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_CHK_IMG,
    ST_NV_RD,
    ST_CHK_NV,
    ST_LOADER,
    ST_NV_WR,
    ST_START
  } seq_state_e;

  // One byte folded into the running CRC, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [7:0]  din);
    logic [15:0] c;
    c = crc_in ^ {din, 8'h00};
    for (int b = 0; b < 8; b++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/bcs_crc16_acc.sv
module bcs_crc16_acc
  import boot_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= CRC_SEED;
    end else if (en) begin
      crc <= crc16_step(crc, din);
    end
  end

endmodule

// File: rtl/bcs_burst_reader.sv
module bcs_burst_reader #(
  parameter int AW         = 16,
  parameter int BASE       = 0,
  parameter int COUNT      = 2,
  parameter bit AUTO_START = 1'b0,
  localparam int CW        = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          dv,
  output logic [CW-1:0] didx,
  output logic          last
);

  localparam logic [CW-1:0] LAST_IDX = CW'(COUNT - 1);
  localparam logic [AW-1:0] BASE_A   = AW'(BASE);

  logic          active;
  logic [CW-1:0] idx;
  logic          dv_q;
  logic [CW-1:0] didx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= AUTO_START;
      idx    <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST_IDX) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  // Data returns one cycle after the request; tag it with its index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      didx_q <= '0;
    end else begin
      dv_q   <= active;
      didx_q <= idx;
    end
  end

  assign rd_en   = active;
  assign rd_addr = BASE_A + AW'(idx);
  assign dv      = dv_q;
  assign didx    = didx_q;
  assign last    = dv_q && (didx_q == LAST_IDX);

  // R1
  burst_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx != LAST_IDX && !go) |=> (rd_en && rd_addr == $past(rd_addr) + AW'(1)));

endmodule

// File: rtl/bcs_recovery_timer.sv
module bcs_recovery_timer #(
  parameter int TICK_DIV      = 50_000_000,
  parameter int TIMEOUT_TICKS = 30,
  localparam int PW           = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
  localparam int TW           = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);

  localparam logic [PW-1:0] PRE_TOP  = PW'(TICK_DIV - 1);
  localparam logic [TW-1:0] TICK_TOP = TW'(TIMEOUT_TICKS - 1);

  logic [PW-1:0] pre;
  logic [TW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ticks <= '0;
    end else if (!en) begin
      pre   <= '0;
      ticks <= '0;
    end else if (pre == PRE_TOP) begin
      pre   <= '0;
      ticks <= ticks + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  assign expired = en && (pre == PRE_TOP) && (ticks == TICK_TOP);

  // R8
  expire_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (pre == '0 && ticks == '0));

endmodule

// File: rtl/bcs_nv_writer.sv
module bcs_nv_writer #(
  parameter int AW   = 10,
  parameter int BASE = 'h3FE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [15:0]   value,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_ready,
  output logic          finished
);

  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic active;
  logic second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      second <= 1'b0;
    end else if (go) begin
      active <= 1'b1;
      second <= 1'b0;
    end else if (active && wr_ready) begin
      if (second) active <= 1'b0;
      second <= 1'b1;
    end
  end

  assign wr_valid = active;
  assign wr_addr  = BASE_A + AW'(second);
  assign wr_data  = second ? value[7:0] : value[15:8];
  assign finished = active && wr_ready && second;

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/boot_crc_seq.sv
module boot_crc_seq
  import boot_crc_pkg::*;
#(
  parameter int PM_AW         = 16,
  parameter int IMG_FIRST     = 'h0800,
  parameter int IMG_LAST      = 'hFFFD,
  parameter int NV_AW         = 10,
  parameter int NV_CRC_ADDR   = 'h3FE,
  parameter int TICK_DIV      = 50_000_000,
  parameter int TIMEOUT_TICKS = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             pm_rd_en,
  output logic [PM_AW-1:0] pm_addr,
  input  logic [7:0]       pm_rdata,
  output logic             nv_rd_en,
  output logic [NV_AW-1:0] nv_rd_addr,
  input  logic [7:0]       nv_rdata,
  output logic             nv_wr_valid,
  output logic [NV_AW-1:0] nv_wr_addr,
  output logic [7:0]       nv_wr_data,
  input  logic             nv_wr_ready,
  input  logic             ldr_activity,
  output logic             loader_mode,
  output logic             ind_a,
  output logic             ind_b,
  output logic             img_valid,
  output logic             start_app
);

  localparam int IMG_BYTES  = IMG_LAST - IMG_FIRST + 1;
  localparam int SCAN_BYTES = IMG_BYTES + 2;
  localparam int PM_CW      = (SCAN_BYTES > 1) ? $clog2(SCAN_BYTES) : 1;
  localparam logic [PM_CW-1:0] HI_IDX = PM_CW'(IMG_BYTES);
  localparam logic [PM_CW-1:0] LO_IDX = PM_CW'(IMG_BYTES + 1);

  seq_state_e state, state_d;

  logic             pm_dv, pm_last;
  logic [PM_CW-1:0] pm_didx;
  logic             nv_dv, nv_last, nv_go;
  logic [0:0]       nv_didx;
  logic [15:0]      crc, stored, nv_copy;
  logic             img_match, nv_match;
  logic             armed, tmr_en, tmr_expired;
  logic             wr_go, wr_finished;

  // Image plus stored checksum stream, starts straight out of reset.
  bcs_burst_reader #(
    .AW(PM_AW), .BASE(IMG_FIRST), .COUNT(SCAN_BYTES), .AUTO_START(1'b1)
  ) u_pm_rd (
    .clk(clk), .rst_n(rst_n), .go(1'b0),
    .rd_en(pm_rd_en), .rd_addr(pm_addr),
    .dv(pm_dv), .didx(pm_didx), .last(pm_last)
  );

  bcs_crc16_acc u_crc (
    .clk(clk), .rst_n(rst_n),
    .en(pm_dv && (pm_didx < HI_IDX)),
    .din(pm_rdata), .crc(crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored <= '0;
    end else if (pm_dv) begin
      if (pm_didx == HI_IDX) stored[15:8] <= pm_rdata;
      if (pm_didx == LO_IDX) stored[7:0]  <= pm_rdata;
    end
  end

  // Nonvolatile copy fetch, launched on an image match.
  assign nv_go = (state == ST_CHK_IMG) && img_match;

  bcs_burst_reader #(
    .AW(NV_AW), .BASE(NV_CRC_ADDR), .COUNT(2), .AUTO_START(1'b0)
  ) u_nv_rd (
    .clk(clk), .rst_n(rst_n), .go(nv_go),
    .rd_en(nv_rd_en), .rd_addr(nv_rd_addr),
    .dv(nv_dv), .didx(nv_didx), .last(nv_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_copy <= '0;
    end else if (nv_dv) begin
      if (nv_didx == 1'b0) nv_copy[15:8] <= nv_rdata;
      else                 nv_copy[7:0]  <= nv_rdata;
    end
  end

  assign img_match = (crc == stored);
  assign nv_match  = (crc == nv_copy);

  // Recovery arming and timer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      img_valid <= 1'b0;
    end else begin
      if (state == ST_LOADER && ldr_activity) armed <= 1'b0;
      if (state == ST_CHK_IMG && img_match) img_valid <= 1'b1;
    end
  end

  assign tmr_en = (state == ST_LOADER) && img_valid && armed && !ldr_activity;

  bcs_recovery_timer #(
    .TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .expired(tmr_expired)
  );

  assign wr_go = (state == ST_LOADER) && tmr_expired;

  bcs_nv_writer #(
    .AW(NV_AW), .BASE(NV_CRC_ADDR)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .value(crc),
    .wr_valid(nv_wr_valid), .wr_addr(nv_wr_addr), .wr_data(nv_wr_data),
    .wr_ready(nv_wr_ready), .finished(wr_finished)
  );

  // Decision sequencer.
  always_comb begin
    state_d = state;
    unique case (state)
      ST_SCAN:    if (pm_last) state_d = ST_CHK_IMG;
      ST_CHK_IMG: state_d = img_match ? ST_NV_RD : ST_LOADER;
      ST_NV_RD:   if (nv_last) state_d = ST_CHK_NV;
      ST_CHK_NV:  state_d = nv_match ? ST_START : ST_LOADER;
      ST_LOADER:  if (tmr_expired) state_d = ST_NV_WR;
      ST_NV_WR:   if (wr_finished) state_d = ST_START;
      ST_START:   state_d = ST_START;
      default:    state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SCAN;
    else        state <= state_d;
  end

  assign loader_mode = (state == ST_LOADER) || (state == ST_NV_WR);
  assign ind_a       = loader_mode;
  assign ind_b       = loader_mode;
  assign start_app   = (state == ST_START);

  // R11
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_app |=> start_app);

  // R11
  start_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_app |-> img_valid);

  // R10
  no_write_unless_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_valid |-> img_valid);

  // R9
  activity_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loader_mode && ldr_activity && !nv_wr_valid) |=> !nv_wr_valid);

  // R3
  no_decision_while_scanning_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |-> (!loader_mode && !start_app && !img_valid));

  // R8
  single_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expired |=> !tmr_expired);

endmodule

// File: tb/tb_boot_crc_seq.sv
module tb_boot_crc_seq;

  localparam int CLK_PERIOD = 10;
  localparam int FIRST = 'h10;
  localparam int LAST  = 'h18;
  localparam int N     = LAST - FIRST + 3;
  localparam int NVA   = 'h3FE;
  localparam int DIV   = 5;
  localparam int TICKS = 4;
  localparam int RUN   = 110;
  localparam int NEVER = 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_rd_en;
  logic [15:0] pm_addr;
  logic [7:0]  pm_rdata;
  logic        nv_rd_en;
  logic [9:0]  nv_rd_addr;
  logic [7:0]  nv_rdata;
  logic        nv_wr_valid;
  logic [9:0]  nv_wr_addr;
  logic [7:0]  nv_wr_data;
  logic        nv_wr_ready;
  logic        ldr_activity = 1'b0;
  logic        loader_mode, ind_a, ind_b, img_valid, start_app;

  logic [7:0] pm [0:255];
  logic [7:0] nv [0:1023];

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_crc_seq #(
    .PM_AW(16), .IMG_FIRST(FIRST), .IMG_LAST(LAST), .NV_AW(10),
    .NV_CRC_ADDR(NVA), .TICK_DIV(DIV), .TIMEOUT_TICKS(TICKS)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .pm_rd_en(pm_rd_en), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .nv_rd_en(nv_rd_en), .nv_rd_addr(nv_rd_addr), .nv_rdata(nv_rdata),
    .nv_wr_valid(nv_wr_valid), .nv_wr_addr(nv_wr_addr), .nv_wr_data(nv_wr_data),
    .nv_wr_ready(nv_wr_ready), .ldr_activity(ldr_activity),
    .loader_mode(loader_mode), .ind_a(ind_a), .ind_b(ind_b),
    .img_valid(img_valid), .start_app(start_app)
  );

  // Memory models: one-cycle read latency; write accepted one cycle after offer.
  always @(posedge clk) begin
    if (pm_rd_en) pm_rdata <= pm[pm_addr[7:0]];
    if (nv_rd_en) nv_rdata <= nv[nv_rd_addr];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_wr_ready <= 1'b0;
    end else if (nv_wr_valid && !nv_wr_ready) begin
      nv[nv_wr_addr] <= nv_wr_data;
      nv_wr_ready    <= 1'b1;
    end else begin
      nv_wr_ready <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Bit-serial reference checksum over the image bytes.
  function automatic logic [15:0] ref_crc();
    logic [15:0] r;
    r = 16'hFFFF;
    for (int a = FIRST; a <= LAST; a++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = r[15] ^ pm[a][b];
        r  = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    end
    return r;
  endfunction

  task automatic load_digits();
    for (int i = 0; i < 9; i++) pm[FIRST + i] = 8'h31 + 8'(i);
  endtask

  task automatic run_case(input int act);
    logic [15:0] c, st, cp;
    logic [7:0]  hi0, lo0;
    bit img_ok, nv_ok;
    int tl, ts, w0;
    c   = ref_crc();
    st  = {pm[LAST + 1], pm[LAST + 2]};
    cp  = {nv[NVA], nv[NVA + 1]};
    hi0 = nv[NVA];
    lo0 = nv[NVA + 1];
    img_ok = (st == c);
    nv_ok  = (cp == c);
    tl = NEVER; ts = NEVER; w0 = NEVER;
    if (!img_ok) tl = N + 2;
    else if (nv_ok) ts = N + 6;
    else begin
      tl = N + 6;
      if (act < 0) begin
        w0 = tl + DIV * TICKS;
        ts = w0 + 4;
      end
    end

    rst_n = 1'b0;
    ldr_activity = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(!start_app && !loader_mode && !img_valid, "R11 reset",
        {start_app, loader_mode, img_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int cyc = 0; cyc < RUN; cyc++) begin
      bit pe, ne, we, le, se, ve;
      pe = (cyc < N);
      ne = img_ok && (cyc == N + 2 || cyc == N + 3);
      ve = img_ok && (cyc >= N + 2);
      le = (cyc >= tl) && (cyc < ts);
      se = (cyc >= ts);
      we = (cyc >= w0) && (cyc < w0 + 4);
      chk(pm_rd_en == pe, "R1 pm_rd_en", pm_rd_en, pe);
      if (pe) chk(pm_addr == 16'(FIRST + cyc), "R1 pm_addr", pm_addr, FIRST + cyc);
      chk(nv_rd_en == ne, "R4 nv_rd_en", nv_rd_en, ne);
      if (ne) chk(nv_rd_addr == 10'(NVA + cyc - N - 2), "R4 nv_rd_addr",
                  nv_rd_addr, NVA + cyc - N - 2);
      chk(img_valid == ve, "R3/R4 img_valid", img_valid, ve);
      chk(loader_mode == le, "R3/R6/R9 loader_mode", loader_mode, le);
      chk(ind_a == le && ind_b == le, "R7 indicators", {ind_a, ind_b}, {le, le});
      chk(start_app == se, "R5/R8/R10 start_app", start_app, se);
      chk(nv_wr_valid == we, "R8/R9/R10 nv_wr_valid", nv_wr_valid, we);
      if (we) begin
        chk(nv_wr_addr == 10'((cyc < w0 + 2) ? NVA : NVA + 1), "R8 nv_wr_addr",
            nv_wr_addr, (cyc < w0 + 2) ? NVA : NVA + 1);
        chk(nv_wr_data == ((cyc < w0 + 2) ? c[15:8] : c[7:0]), "R8 nv_wr_data",
            nv_wr_data, (cyc < w0 + 2) ? c[15:8] : c[7:0]);
      end
      ldr_activity = (cyc == act);
      @(negedge clk);
      #1;
    end
    ldr_activity = 1'b0;
    if (w0 < NEVER) begin
      chk(nv[NVA] == c[15:8] && nv[NVA + 1] == c[7:0], "R8 copy rewritten",
          {nv[NVA], nv[NVA + 1]}, c);
    end else begin
      chk(nv[NVA] == hi0 && nv[NVA + 1] == lo0, "R9/R10 copy untouched",
          {nv[NVA], nv[NVA + 1]}, {hi0, lo0});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pm[i] = 8'h00;
    for (int i = 0; i < 1024; i++) nv[i] = 8'h00;

    // R2 R5: known vector, both copies correct
    load_digits();
    pm[LAST + 1] = 8'h29; pm[LAST + 2] = 8'hB1;
    nv[NVA] = 8'h29; nv[NVA + 1] = 8'hB1;
    run_case(-1);

    // R5: different image pattern, both copies correct
    for (int i = 0; i < 9; i++) pm[FIRST + i] = 8'(i * 37 + 5);
    {pm[LAST + 1], pm[LAST + 2]} = ref_crc();
    {nv[NVA], nv[NVA + 1]} = ref_crc();
    run_case(-1);

    // R3 R10: stored checksum wrong in its low byte
    load_digits();
    pm[LAST + 1] = 8'h29; pm[LAST + 2] = 8'hB2;
    nv[NVA] = 8'h29; nv[NVA + 1] = 8'hB1;
    run_case(-1);

    // R6 R8 R2: copy cleared, recovery writes 0x29 then 0xB1
    load_digits();
    pm[LAST + 1] = 8'h29; pm[LAST + 2] = 8'hB1;
    nv[NVA] = 8'h00; nv[NVA + 1] = 8'h00;
    run_case(-1);
    chk(nv[NVA] == 8'h29 && nv[NVA + 1] == 8'hB1, "R2 known vector 29B1",
        {nv[NVA], nv[NVA + 1]}, 16'h29B1);

    // R9: copy wrong, loader activity at cycle N+13 cancels recovery
    nv[NVA] = 8'h29; nv[NVA + 1] = 8'h00;
    run_case(N + 13);

    // R8: all-ones image, copy high byte wrong
    for (int i = 0; i < 9; i++) pm[FIRST + i] = 8'hFF;
    {pm[LAST + 1], pm[LAST + 2]} = ref_crc();
    {nv[NVA], nv[NVA + 1]} = ref_crc() ^ 16'h8000;
    run_case(-1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule